// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause 22 management master for the serial MDC/MDIO pair that links a MAC-side controller to its PHYs. Software describes a whole transaction in one 32-bit control word. The word carries the write data, the register address, the PHY address, a read/write select, an enable and a busy flag. Writing the word with busy and enable both set starts a frame. The controller derives MDC from the system clock and shifts the frame out MSB first. On a read it releases the line for the turnaround and collects the sixteen bits the PHY returns.

When the frame is done, the controller clears busy in the same register. For a read it also replaces the low sixteen bits of that register with the returned data. Software polls the register until busy drops and then takes the result from the same word.

A PHY address at or above the implemented count is refused at once, and no clock pulses are sent. A write to the control word while busy is set is discarded.

Top module: `mdio_master`

## Requirements
- R1: The control word layout is fixed: bits [15:0] hold the data, [20:16] the register address, [25:21] the PHY address, bit 27 selects a read (1) or a write (0), bit 30 is the enable and bit 31 is busy. The remaining bits are stored and read back as written. A write word with busy=1, enable=1 and a valid PHY produces a 64-bit frame, sent MSB first: 32 ones, start `01`, opcode `01`, PHY address, register address, turnaround `10`, and the 16 data bits.
- R2: A read word (bit 27 set) sends opcode `10`. The 16 bits sampled after the turnaround replace bits [15:0] of the control word. Bits [30:16] keep their written values.
- R3: Busy stays set for exactly 128*DIV_HALF system clock cycles, counted from the write that started the frame, and then clears by itself.
- R4: A word with busy=1 and enable=1 whose PHY address is NUM_PHYS or more sends no MDC pulse and reads back with busy clear. For a read, bits [15:0] then read 0xFFFF. For a write, the data field is left as written.
- R5: A control write issued while busy is set is ignored. The frame in flight is not altered, and the word read back at completion is the one that started it.
- R6: MDC is high for DIV_HALF cycles and low for DIV_HALF cycles. The master changes MDIO and its output enable only while MDC falls. A frame has exactly 64 MDC rising edges.
- R7: During a read, the master drives MDIO through bit 45 of the frame and releases it (output enable low) from the first turnaround bit (bit 46) to the end.
- R8: A word with busy=1 and enable=0 starts no frame and is stored with busy cleared.
- R9: Out of reset, and whenever busy is clear, the control word reads back as last stored (0 after reset), MDC is low, and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write value |
| ctrl_rdata_o | output | 32 | Control word read value |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The bench builds the block with DIV_HALF=2 and NUM_PHYS=5. This keeps a frame at 256 cycles. At that length every register address on every valid PHY can be read and written, and every out-of-range PHY address from 5 to 31 can be tried, within the run budget. A PHY model on the pad captures each frame bit at the MDC rising edge and answers reads with data computed from the PHY and register addresses. Whole frames, the turnaround release and the returned data are therefore checked against arithmetic expectations. Short DIV_HALF also lets the exact busy length and the MDC high time be counted cycle by cycle for every frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_W    = 32;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int REG_LSB   = 16;
  localparam int PHY_LSB   = 21;
  localparam int RD_BIT    = 27;
  localparam int EN_BIT    = 30;
  localparam int BUSY_BIT  = 31;
  localparam int FRAME_W   = 64;
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rega,
    input logic [DATA_W-1:0] wd
  );
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rega, 2'b10,
            (rd ? 16'hFFFF : wd)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int H  = (DIV_HALF < 2) ? 2 : DIV_HALF;
  localparam int CW = $clog2(H);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(H - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MDC_LOW_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o); // R9
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               last_q, rd_q, oe_q, act_q;
  logic [DATA_W-1:0]  rx_q;
  logic [IDX_W:0]     idx_nx;

  assign idx_nx    = {1'b0, idx_q} + 1'b1;
  assign done_o    = act_q && fall_i && last_q;
  assign active_o  = act_q;
  assign mdio_o    = sh_q[FRAME_W-1];
  assign mdio_oe_o = oe_q;
  assign rdata_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      act_q  <= 1'b0;
      rx_q   <= '0;
    end else if (start_i) begin
      sh_q   <= build_frame(rd_i, phy_i, reg_i, wdata_i);
      idx_q  <= '0;
      last_q <= 1'b0;
      rd_q   <= rd_i;
      oe_q   <= 1'b1;
      act_q  <= 1'b1;
      rx_q   <= '0;
    end else if (act_q) begin
      if (rise_i) begin
        if (rd_q && (int'(idx_q) >= DATA_IDX)) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        if (idx_q == IDX_W'(FRAME_W - 1)) last_q <= 1'b1;
      end
      if (fall_i) begin
        if (last_q) begin
          act_q  <= 1'b0;
          oe_q   <= 1'b0;
          last_q <= 1'b0;
        end else begin
          idx_q <= idx_nx[IDX_W-1:0];
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          oe_q  <= !(rd_q && (int'(idx_nx) >= TA_IDX));
        end
      end
    end
  end

  AST_TA_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && rd_q && (int'(idx_q) >= TA_IDX) |-> !mdio_oe_o); // R7
  AST_WRITE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !rd_q |-> mdio_oe_o); // R1
  AST_NO_SAMPLE_AND_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && fall_i)); // R6
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int NUM_PHYS = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  output logic [31:0] ctrl_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [WORD_W-1:0] ctrl_q;
  logic              busy, accept, req, phy_ok, go, done, active, rise, fall;
  logic [ADDR_W-1:0] wd_phy, wd_reg;
  logic [DATA_W-1:0] rx;

  assign busy   = ctrl_q[BUSY_BIT];
  assign wd_phy = ctrl_wdata_i[PHY_LSB +: ADDR_W];
  assign wd_reg = ctrl_wdata_i[REG_LSB +: ADDR_W];
  assign phy_ok = 32'(wd_phy) < NUM_PHYS;
  assign accept = ctrl_we_i && !busy;
  assign req    = ctrl_wdata_i[BUSY_BIT] && ctrl_wdata_i[EN_BIT];
  assign go     = accept && req && phy_ok;
  assign ctrl_rdata_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (accept) begin
      if (go)
        ctrl_q <= ctrl_wdata_i;
      else if (req && ctrl_wdata_i[RD_BIT])
        ctrl_q <= {1'b0, ctrl_wdata_i[WORD_W-2:DATA_W], 16'hFFFF};
      else
        ctrl_q <= {1'b0, ctrl_wdata_i[WORD_W-2:0]};
    end else if (done) begin
      ctrl_q[BUSY_BIT] <= 1'b0;
      if (ctrl_q[RD_BIT]) ctrl_q[DATA_W-1:0] <= rx;
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (go),
    .rd_i      (ctrl_wdata_i[RD_BIT]),
    .phy_i     (wd_phy),
    .reg_i     (wd_reg),
    .wdata_i   (ctrl_wdata_i[DATA_W-1:0]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (active),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (rx)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o && !mdio_oe_o); // R9
  AST_BUSY_MEANS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> active); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy); // R3
  AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o) && $stable(mdio_oe_o)); // R6
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ctrl_we_i |=> $stable(ctrl_q[WORD_W-2:DATA_W])); // R5
  AST_BAD_PHY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && req && !phy_ok |=> !busy && !mdc_o); // R4
  AST_DISABLED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ctrl_wdata_i[BUSY_BIT] && !ctrl_wdata_i[EN_BIT] |=> !busy); // R8
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int HALF = 2;
  localparam int NPHY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_drv, mdio_oe;
  logic        phy_oe = 1'b0, phy_val = 1'b1;
  logic        line;
  int          checks = 0, errors = 0, rises = 0;
  logic [63:0] cap = '0;
  logic [63:0] oe_at = '0;
  bit          finished = 0;

  always #4 clk = ~clk;

  assign line = mdio_oe ? mdio_drv : (phy_oe ? phy_val : 1'b1);

  mdio_master #(.DIV_HALF(HALF), .NUM_PHYS(NPHY)) i_mdio_master (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_we_i    (we),
    .ctrl_wdata_i (wdata),
    .ctrl_rdata_o (rdata),
    .mdc_o        (mdc),
    .mdio_i       (line),
    .mdio_o       (mdio_drv),
    .mdio_oe_o    (mdio_oe)
  );

  function automatic logic [15:0] phy_data(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h2A} ^ 16'h9C31;
  endfunction

  // PHY model: sample on MDC rise, answer reads after MDC fall
  always @(posedge mdc) begin
    if (rises < 64) begin
      cap[63-rises]   = line;
      oe_at[63-rises] = mdio_oe;
    end
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 47 && rises <= 63 && cap[29:28] == 2'b10) begin
      phy_oe  = 1'b1;
      phy_val = (rises == 47) ? 1'b0 : phy_data(cap[27:23], cap[22:18])[63-rises];
    end else begin
      phy_oe = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1;
    wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] w, output int cyc, output int hi);
    rises = 0;
    cyc = 0;
    hi = 0;
    write_ctrl(w);
    while (rdata[31] && cyc < 10000) begin
      cyc++;
      if (mdc) hi++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input bit en, input bit bsy,
                                     input logic [4:0] p, input logic [4:0] r,
                                     input logic [15:0] d);
    return {bsy, en, 2'b00, rd, 1'b0, p, r, d};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc, hi;
    logic [31:0] w, w2;
    logic [15:0] d, pd;
    logic [63:0] exp;

    repeat (3) @(negedge clk);
    chk(rdata == 32'h0, "R9 reset word", 64'(rdata), 64'h0);
    chk(!mdc && !mdio_oe, "R9 reset lines", {62'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int p = 0; p < NPHY; p++) begin
      for (int r = 0; r < 32; r++) begin
        // write frame
        d = {p[4:0], r[4:0], 6'h15} ^ 16'h3C0F;
        w = mk(1'b0, 1'b1, 1'b1, p[4:0], r[4:0], d);
        w[28] = r[0];
        run_frame(w, cyc, hi);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p[4:0], r[4:0], 2'b10, d};
        chk(cap == exp && rises == 64, "R1 write frame", cap, exp);
        chk(cyc == 128*HALF, "R3 busy length write", 64'(cyc), 64'(128*HALF));
        chk(hi == 64*HALF, "R6 mdc high time", 64'(hi), 64'(64*HALF));
        chk(rdata == {1'b0, w[30:0]}, "R3 write done word", 64'(rdata), 64'({1'b0, w[30:0]}));
        chk(!mdc && !mdio_oe, "R9 idle after write", {62'h0, mdc, mdio_oe}, 64'h0);
        // read frame
        w = mk(1'b1, 1'b1, 1'b1, p[4:0], r[4:0], 16'h1234);
        run_frame(w, cyc, hi);
        pd = phy_data(p[4:0], r[4:0]);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p[4:0], r[4:0], 2'b10, pd};
        chk(cap == exp && rises == 64, "R2 read frame", cap, exp);
        chk(oe_at[63-45] && oe_at[17:0] == 18'h0, "R7 turnaround release", oe_at, 64'h0);
        chk(rdata == {1'b0, w[30:16], pd}, "R2 read data word", 64'(rdata), 64'({1'b0, w[30:16], pd}));
        chk(cyc == 128*HALF, "R3 busy length read", 64'(cyc), 64'(128*HALF));
      end
    end

    for (int p = NPHY; p < 32; p++) begin
      rises = 0;
      w = mk(1'b1, 1'b1, 1'b1, p[4:0], 5'd3, 16'h0BAD);
      write_ctrl(w);
      chk(rdata == {1'b0, w[30:16], 16'hFFFF}, "R4 bad phy read", 64'(rdata), 64'({1'b0, w[30:16], 16'hFFFF}));
      w = mk(1'b0, 1'b1, 1'b1, p[4:0], 5'd9, 16'h5A5A);
      write_ctrl(w);
      repeat (8) @(negedge clk);
      chk(rdata == {1'b0, w[30:0]}, "R4 bad phy write", 64'(rdata), 64'({1'b0, w[30:0]}));
      chk(rises == 0, "R4 no mdc pulse", 64'(rises), 64'h0);
    end

    rises = 0;
    w = mk(1'b0, 1'b0, 1'b1, 5'd1, 5'd2, 16'hBEEF);
    write_ctrl(w);
    repeat (10) @(negedge clk);
    chk(rdata == {1'b0, w[30:0]}, "R8 disabled word", 64'(rdata), 64'({1'b0, w[30:0]}));
    chk(rises == 0, "R8 no frame", 64'(rises), 64'h0);

    // write during busy
    rises = 0;
    w  = mk(1'b0, 1'b1, 1'b1, 5'd2, 5'd7, 16'hC0DE);
    w2 = mk(1'b1, 1'b1, 1'b1, 5'd4, 5'd1, 16'h0001);
    write_ctrl(w);
    repeat (50) @(negedge clk);
    write_ctrl(w2);
    chk(rdata == w, "R5 word held while busy", 64'(rdata), 64'(w));
    cyc = 0;
    while (rdata[31] && cyc < 10000) begin cyc++; @(negedge clk); end
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd7, 2'b10, 16'hC0DE};
    chk(cap == exp, "R5 frame unaltered", cap, exp);
    chk(rdata == {1'b0, w[30:0]}, "R5 final word", 64'(rdata), 64'({1'b0, w[30:0]}));

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule